// File: doc/BRIEF.md
# Tracking Angle Readout Interface

This block sits after a tracking loop that reports its angle as single-LSB steps, and in front of a host that reads the angle one byte at a time. It keeps its own 16-bit angle counter, which moves by one LSB up or down on each step. Every step produces one busy pulse of fixed width. A host can use the pulse to avoid sampling while the value is moving.

A readout register sits between the counter and the host bus. While the active-low hold input is released, the register follows the counter on every clock edge. While the hold is asserted, the register keeps its contents and the counter keeps tracking. Busy pulses are still produced during a hold. When the hold is released, the register picks up the full counter value on the next edge.

The host reads the register through two active-low byte enables: one for the upper byte and one for the lower byte. The three-state bus is modelled as a byte of data plus an output-enable flag. When both enables are asserted together, the upper byte is driven and a one-cycle protocol-error flag is raised.

Top module: `angle_readout_if`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `bus_oe` and `proto_err` are 0, and the readout register and the counter hold angle 0.
- R2: A cycle with `step_valid`=1 changes the counter by +1 when `step_up`=1 and by -1 when `step_up`=0, modulo 2^16. Stepping down from 0x0000 gives 0xFFFF, and stepping up from 0xFFFF gives 0x0000.
- R3: Each step produces exactly one busy pulse of `BUSY_CYCLES` cycles (default 4). When the pulse generator is idle, `busy` rises in the cycle after the edge that samples the step.
- R4: Steps that arrive while a pulse is in progress are counted as pending. Each pending step gets its own pulse. Consecutive pulses are separated by exactly one low cycle. At most 2^`PEND_W`-1 steps can be pending, and any beyond that are dropped.
- R5: At each edge where `inh_n`=1, the readout register takes the counter value that results from that edge. The new angle is therefore readable for the whole busy pulse of that step.
- R6: At each edge where `inh_n`=0, the readout register keeps its value. The counter keeps following steps, and the busy pulses are still produced.
- R7: At the first edge with `inh_n`=1 after a hold, the readout register takes the counter value, including every step taken during the hold.
- R8: With `en_msb_n`=0, `bus_oe`=1 and `bus_data` is bits 15:8 of the readout register. With `en_msb_n`=1 and `en_lsb_n`=0, `bus_oe`=1 and `bus_data` is bits 7:0.
- R9: With both enables at 1, `bus_oe`=0 and `bus_data`=0.
- R10: When both enables are 0, the upper byte is driven. `proto_err` is 1 for exactly one cycle, in the cycle after the first edge of each overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_valid | input | 1 | One-LSB step of the tracked angle this cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| inh_n | input | 1 | Active-low hold of the readout register |
| en_msb_n | input | 1 | Active-low enable of the upper angle byte |
| en_lsb_n | input | 1 | Active-low enable of the lower angle byte |
| busy | output | 1 | Busy pulse, one per step |
| bus_data | output | 8 | Byte driven onto the host bus (0 when not driven) |
| bus_oe | output | 1 | Bus output enable (0 = high impedance) |
| proto_err | output | 1 | One-cycle flag for both enables asserted together |

## Verification
The bench goes after wrap-around in both directions. An adder that is too narrow, or that saturates, would return 0xFFFF or 0x0000 wrongly on the bus. It drives back-to-back step bursts: a generator that merges pulses, or that leaves no gap, would show fewer rising edges than steps, or a pulse of the wrong width. It steps the counter during a hold. A design that lets the hold stop tracking would return a stale angle after release, and one that ignores the hold would show the new angle on the bus. Overlapping byte enables check both the priority and the flag: a design that picks the lower byte, or that holds the flag for the whole overlap, differs from the reference on the first cycle.

// File: rtl/angle_rd_pkg.sv
package angle_rd_pkg;

  typedef enum logic [1:0] {
    BSEL_NONE = 2'd0,
    BSEL_HI   = 2'd1,
    BSEL_LO   = 2'd2
  } byte_sel_e;

endpackage

// File: rtl/rd_reset_sync.sv
module rd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/angle_track_ctr.sv
module angle_track_ctr #(
  parameter int ANGLE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_valid,
  input  logic               step_up,
  output logic [ANGLE_W-1:0] cnt_q,
  output logic [ANGLE_W-1:0] cnt_d
);

  localparam logic [ANGLE_W-1:0] ONE = ANGLE_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (step_valid) begin
      if (step_up) begin
        cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_valid) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/busy_pulse_gen.sv
module busy_pulse_gen #(
  parameter int BUSY_CYCLES = 4,
  parameter int PEND_W      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_valid,
  output logic busy
);

  localparam int PH_W = $clog2(BUSY_CYCLES + 2);
  localparam logic [PH_W-1:0]   PH_LOAD  = PH_W'(BUSY_CYCLES + 1);
  localparam logic [PH_W-1:0]   PH_ONE   = PH_W'(1);
  localparam logic [PH_W-1:0]   PH_TWO   = PH_W'(2);
  localparam logic [PEND_W:0]   PEND_MAX = {1'b0, {PEND_W{1'b1}}};

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              busy_q, busy_d;
  logic              start;
  logic [PEND_W:0]   pend_sum;

  always_comb begin
    start = (ph_q <= PH_ONE) && (step_valid || (pend_q != '0));

    if (start) begin
      ph_d = PH_LOAD;
    end else if (ph_q != '0) begin
      ph_d = ph_q - PH_ONE;
    end else begin
      ph_d = ph_q;
    end

    pend_sum = {1'b0, pend_q} + {{PEND_W{1'b0}}, step_valid}
             - {{PEND_W{1'b0}}, start};
    if (pend_sum > PEND_MAX) begin
      pend_d = PEND_MAX[PEND_W-1:0];
    end else begin
      pend_d = pend_sum[PEND_W-1:0];
    end

    busy_d = (ph_d >= PH_TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/readout_latch.sv
module readout_latch #(
  parameter int ANGLE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inh_n,
  input  logic [ANGLE_W-1:0] cnt_d,
  output logic [ANGLE_W-1:0] lat_q
);

  logic [ANGLE_W-1:0] lat_d;
  logic               lat_en;

  always_comb begin
    lat_en = inh_n;
    lat_d  = cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

endmodule

// File: rtl/byte_bus_mux.sv
module byte_bus_mux
  import angle_rd_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] lat_q,
  input  logic               en_msb_n,
  input  logic               en_lsb_n,
  output logic [BYTE_W-1:0]  bus_data,
  output logic               bus_oe,
  output logic               proto_err
);

  localparam int NBYTES = ANGLE_W / BYTE_W;

  logic [BYTE_W-1:0] byte_a [NBYTES];
  byte_sel_e         sel;
  logic              both, both_q, err_q, err_d;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slice
    assign byte_a[g] = lat_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (!en_msb_n) begin
      sel = BSEL_HI;
    end else if (!en_lsb_n) begin
      sel = BSEL_LO;
    end else begin
      sel = BSEL_NONE;
    end

    unique case (sel)
      BSEL_HI: begin
        bus_data = byte_a[NBYTES-1];
        bus_oe   = 1'b1;
      end
      BSEL_LO: begin
        bus_data = byte_a[0];
        bus_oe   = 1'b1;
      end
      default: begin
        bus_data = '0;
        bus_oe   = 1'b0;
      end
    endcase

    both  = !en_msb_n && !en_lsb_n;
    err_d = both && !both_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      both_q <= both;
      err_q  <= err_d;
    end
  end

  assign proto_err = err_q;

endmodule

// File: rtl/angle_readout_if.sv
module angle_readout_if #(
  parameter int ANGLE_W     = 16,
  parameter int BYTE_W      = 8,
  parameter int BUSY_CYCLES = 4,
  parameter int PEND_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  input  logic              step_up,
  input  logic              inh_n,
  input  logic              en_msb_n,
  input  logic              en_lsb_n,
  output logic              busy,
  output logic [BYTE_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              proto_err
);

  logic               rst_sync_n;
  logic [ANGLE_W-1:0] cnt_q;
  logic [ANGLE_W-1:0] cnt_d;
  logic [ANGLE_W-1:0] lat_q;

  rd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  angle_track_ctr #(.ANGLE_W(ANGLE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_valid (step_valid),
    .step_up    (step_up),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d)
  );

  busy_pulse_gen #(.BUSY_CYCLES(BUSY_CYCLES), .PEND_W(PEND_W)) u_busy (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_valid (step_valid),
    .busy       (busy)
  );

  readout_latch #(.ANGLE_W(ANGLE_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inh_n (inh_n),
    .cnt_d (cnt_d),
    .lat_q (lat_q)
  );

  byte_bus_mux #(.ANGLE_W(ANGLE_W), .BYTE_W(BYTE_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lat_q     (lat_q),
    .en_msb_n  (en_msb_n),
    .en_lsb_n  (en_lsb_n),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe),
    .proto_err (proto_err)
  );

endmodule

// File: rtl/angle_readout_chk.sv
module angle_readout_chk #(
  parameter int ANGLE_W     = 16,
  parameter int BYTE_W      = 8,
  parameter int BUSY_CYCLES = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               step_valid,
  input logic               inh_n,
  input logic               en_msb_n,
  input logic               en_lsb_n,
  input logic               busy,
  input logic [BYTE_W-1:0]  bus_data,
  input logic               bus_oe,
  input logic               proto_err,
  input logic [ANGLE_W-1:0] cnt_q,
  input logic [ANGLE_W-1:0] lat_q
);

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 16'd1;
    end else begin
      run_q <= '0;
    end
  end

  // R3
  busy_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> (run_q == 16'(BUSY_CYCLES)));

  // R2
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_valid |=> (cnt_q != $past(cnt_q)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !inh_n |=> $stable(lat_q));

  // R7
  follow_ctr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inh_n |=> (lat_q == cnt_q));

  // R8
  msb_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_msb_n |-> (bus_oe && bus_data == lat_q[ANGLE_W-1 -: BYTE_W]));

  // R8
  lsb_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_msb_n && !en_lsb_n) |-> (bus_oe && bus_data == lat_q[BYTE_W-1:0]));

  // R9
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_msb_n && en_lsb_n) |-> (!bus_oe && bus_data == '0));

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    proto_err |=> !proto_err);

endmodule

bind angle_readout_if angle_readout_chk #(
  .ANGLE_W     (ANGLE_W),
  .BYTE_W      (BYTE_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .step_valid (step_valid),
  .inh_n      (inh_n),
  .en_msb_n   (en_msb_n),
  .en_lsb_n   (en_lsb_n),
  .busy       (busy),
  .bus_data   (bus_data),
  .bus_oe     (bus_oe),
  .proto_err  (proto_err),
  .cnt_q      (cnt_q),
  .lat_q      (lat_q)
);

// File: tb/angle_readout_if_tb_top.sv
`timescale 1ns/1ps
module angle_readout_if_tb_top;

  localparam int BUSY = 4;
  localparam int PMAX = 15;

  logic       clk;
  logic       rst_n;
  logic       step_valid, step_up, inh_n, en_msb_n, en_lsb_n;
  logic       busy, bus_oe, proto_err;
  logic [7:0] bus_data;

  int n_tests;
  int n_fail;
  bit done;

  // behavioural reference state
  int m_cnt, m_lat, m_pend, m_left;
  bit m_busy, m_err, m_both_prev;
  int rises;
  bit busy_prev;
  int err_cycles;

  angle_readout_if dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .step_up    (step_up),
    .inh_n      (inh_n),
    .en_msb_n   (en_msb_n),
    .en_lsb_n   (en_lsb_n),
    .busy       (busy),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe),
    .proto_err  (proto_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model update on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lat = 0; m_pend = 0; m_left = 0;
      m_busy = 0; m_err = 0; m_both_prev = 0;
    end else begin
      int tmp;
      bit both;
      if (step_valid) m_cnt = step_up ? (m_cnt + 1) & 16'hFFFF : (m_cnt + 65535) & 16'hFFFF;
      if (inh_n) m_lat = m_cnt;
      tmp = m_pend + (step_valid ? 1 : 0);
      if (m_left > 1) m_left = m_left - 1;
      else if (m_left == 1) m_left = 0;
      else if (tmp > 0) begin
        m_left = BUSY;
        tmp = tmp - 1;
      end
      m_pend = (tmp > PMAX) ? PMAX : tmp;
      m_busy = (m_left > 0);
      both = !en_msb_n && !en_lsb_n;
      m_err = both && !m_both_prev;
      m_both_prev = both;
    end
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int exp_data;
      bit exp_oe;
      if (!en_msb_n) begin exp_oe = 1; exp_data = (m_lat >> 8) & 255; end
      else if (!en_lsb_n) begin exp_oe = 1; exp_data = m_lat & 255; end
      else begin exp_oe = 0; exp_data = 0; end
      chk("R3 busy", int'(busy), int'(m_busy));
      chk("R10 proto_err", int'(proto_err), int'(m_err));
      chk("R9 bus_oe", int'(bus_oe), int'(exp_oe));
      chk("R8 bus_data", int'(bus_data), exp_data);
      if (busy && !busy_prev) rises++;
      if (proto_err) err_cycles++;
      busy_prev = busy;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_step(input bit up);
    @(negedge clk);
    step_valid = 1'b1;
    step_up    = up;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic read_angle(output int val);
    int hi, lo;
    @(negedge clk);
    en_msb_n = 1'b0;
    #2 hi = int'(bus_data);
    @(negedge clk);
    en_msb_n = 1'b1;
    en_lsb_n = 1'b0;
    #2 lo = int'(bus_data);
    @(negedge clk);
    en_lsb_n = 1'b1;
    val = (hi << 8) | lo;
  endtask

  initial begin
    int v, exp_ang, r0, held;
    n_tests = 0; n_fail = 0; done = 0; rises = 0; err_cycles = 0; busy_prev = 0;
    step_valid = 0; step_up = 0; inh_n = 1; en_msb_n = 1; en_lsb_n = 1;
    rst_n = 0;
    idle(3);
    #2;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 bus_oe", int'(bus_oe), 0);
    chk("R1 proto_err", int'(proto_err), 0);
    @(negedge clk);
    rst_n = 1;
    idle(4);
    read_angle(v);
    chk("R1 angle", v, 0);
    exp_ang = 0;

    // R2 wrap down from zero, R3 one pulse
    r0 = rises;
    do_step(1'b0);
    exp_ang = 16'hFFFF;
    idle(BUSY + 3);
    read_angle(v);
    chk("R2 wrap down", v, exp_ang);
    chk("R3 one pulse", rises - r0, 1);
    do_step(1'b1);
    exp_ang = 0;
    idle(BUSY + 3);
    read_angle(v);
    chk("R2 wrap up", v, exp_ang);

    // R5 read during pulse sees new value
    do_step(1'b1);
    exp_ang = 1;
    read_angle(v);
    chk("R5 read in pulse", v, exp_ang);
    idle(BUSY + 2);

    // R4 burst of back-to-back steps
    r0 = rises;
    @(negedge clk);
    step_valid = 1; step_up = 1;
    idle(5);
    step_valid = 0;
    exp_ang = exp_ang + 5;
    idle(6 * (BUSY + 1) + 4);
    chk("R4 pulses for burst", rises - r0, 5);
    read_angle(v);
    chk("R4 angle after burst", v, exp_ang);

    // R6 hold: register frozen, tracking and pulses continue
    @(negedge clk);
    inh_n = 0;
    held = exp_ang;
    r0 = rises;
    do_step(1'b1);
    do_step(1'b1);
    do_step(1'b0);
    do_step(1'b1);
    exp_ang = exp_ang + 2;
    idle(4 * (BUSY + 1) + 4);
    read_angle(v);
    chk("R6 held value", v, held);
    chk("R6 pulses in hold", rises - r0, 4);

    // R7 release picks up all steps
    @(negedge clk);
    inh_n = 1;
    read_angle(v);
    chk("R7 release", v, exp_ang);

    // R10 overlapping enables: msb wins, one-cycle flag
    r0 = err_cycles;
    @(negedge clk);
    en_msb_n = 0; en_lsb_n = 0;
    #2 chk("R10 msb priority", int'(bus_data), (exp_ang >> 8) & 255);
    idle(3);
    en_msb_n = 1; en_lsb_n = 1;
    idle(2);
    chk("R10 flag cycles", err_cycles - r0, 1);
    @(negedge clk);
    #2 chk("R9 released bus", int'(bus_oe), 0);

    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule